// File: doc/BRIEF.md
# Pointer Load/Store Address Generator

This block forms data-memory and program-memory addresses for load and store operations that go through three 16-bit pointer registers: X, Y and Z. A sequencer presents one request at a time. The request carries an operation, a pointer select, an addressing mode, a 6-bit displacement, a 16-bit immediate address and store data. The block keeps the three pointers and writes each updated pointer back to itself. It drives a synchronous single-port data memory and a synchronous program-memory read port, and it returns the loaded byte on a result strobe.

Data-memory accesses last two cycles and program-memory reads last three. A `busy` output stays high for the whole access so that the sequencer stalls. A separate write port lets the surrounding core load a pointer whenever no access is in progress. The three pointers are visible on output ports.

Top module: `ptr_agu`

## Requirements
- R1: After a synchronous active-low reset, all three pointers read 0x0000 and `busy`, `dm_en`, `dm_we`, `pm_en` and `rd_valid` are low.
- R2: Mode 0 (plain) accesses the address held in the selected pointer and leaves that pointer unchanged. Pointer codes are 0 = X, 1 = Y and 2 = Z.
- R3: Mode 1 (post-increment) accesses the old pointer value. The pointer then holds that value plus one, modulo 2^16, so 0xFFFF becomes 0x0000.
- R4: Mode 2 (pre-decrement) first sets the pointer to its value minus one, modulo 2^16, so 0x0000 becomes 0xFFFF. The access then uses that new value.
- R5: Mode 3 (displacement) on Y or Z accesses pointer + q, where q is the unsigned 6-bit displacement and the sum is taken modulo 2^16. The pointer is left unchanged.
- R6: A request is refused when it asks for displacement on X, when its pointer code is 3, when its mode code is above 4, or when its operation code is 3. A refused request raises no busy, enables no memory and changes no pointer.
- R7: Mode 4 (direct) accesses the 16-bit immediate address and changes no pointer.
- R8: Operation 1 (store) supports the same modes as operation 0 (load). In the first access cycle it asserts `dm_en` and `dm_we`, with `dm_wdata` equal to the request's store data, at the computed address.
- R9: A data-memory access holds `busy` high for exactly 2 cycles, starting the cycle after acceptance. For a load, `rd_valid` is high in the cycle right after `busy` falls, and `rd_data` then carries the byte read.
- R10: Operation 2 (program-memory read) always uses Z, whatever the pointer code. It accepts only mode 0 or mode 1, where mode 1 increments Z afterwards. It asserts `pm_en` at Z, holds `busy` for exactly 3 cycles and then returns the byte with `rd_valid`.
- R11: A request presented while `busy` is high is ignored. A request presented in the cycle where `rd_valid` is high is accepted.
- R12: A pointer write through the write port takes effect at the next clock edge only when `busy` is low and `req_valid` is low. In any other cycle the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 0 load, 1 store, 2 program read |
| req_sel | input | 2 | 0 X, 1 Y, 2 Z |
| req_mode | input | 3 | 0 plain, 1 post-inc, 2 pre-dec, 3 displacement, 4 direct |
| req_disp | input | 6 | Unsigned displacement q |
| req_imm | input | 16 | Direct address k |
| req_wdata | input | 8 | Store data |
| ptr_wr_en | input | 1 | Pointer write strobe |
| ptr_wr_sel | input | 2 | Pointer to write |
| ptr_wr_data | input | 16 | Value to write |
| ptr_x | output | 16 | Current X |
| ptr_y | output | 16 | Current Y |
| ptr_z | output | 16 | Current Z |
| busy | output | 1 | Access in progress |
| dm_en | output | 1 | Data memory enable |
| dm_we | output | 1 | Data memory write enable |
| dm_addr | output | 16 | Data memory address |
| dm_wdata | output | 8 | Data memory write data |
| dm_rdata | input | 8 | Data memory read data, one cycle after enable |
| pm_en | output | 1 | Program memory read enable |
| pm_addr | output | 16 | Program memory address |
| pm_rdata | input | 8 | Program memory read data |
| rd_valid | output | 1 | Load result strobe |
| rd_data | output | 8 | Load result |

## Verification
Two functions can fall in one cycle: delivery of a finished load (`rd_valid`) and acceptance of the next request. The bench provokes this by raising a new request exactly in the result cycle. It then judges that the previous load's byte is correct and that the new access's enable and address appear in the following cycle. A second collision is a pointer write arriving together with a request, or during a busy access. It is judged by reading the pointer outputs after the access and confirming that the written value never landed.

// File: rtl/agu_pkg.sv
// Package: shared codes for the pointer address generator.
// Assumes requests use these encodings; codes outside them are refused.
package agu_pkg;
    localparam logic [1:0] OP_LOAD   = 2'd0;
    localparam logic [1:0] OP_STORE  = 2'd1;
    localparam logic [1:0] OP_PMREAD = 2'd2;

    localparam logic [1:0] SEL_X = 2'd0;
    localparam logic [1:0] SEL_Y = 2'd1;
    localparam logic [1:0] SEL_Z = 2'd2;

    localparam logic [2:0] MD_PLAIN  = 3'd0;
    localparam logic [2:0] MD_POSTINC = 3'd1;
    localparam logic [2:0] MD_PREDEC = 3'd2;
    localparam logic [2:0] MD_DISP   = 3'd3;
    localparam logic [2:0] MD_DIRECT = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/agu_ptr_file.sv
// Module: holds the three pointer registers.
// The access update port has priority over the external port. The caller
// gates the external port so that both are never meant to land at once.
module agu_ptr_file #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_we,
    input  logic [1:0]    ext_sel,
    input  logic [AW-1:0] ext_data,
    input  logic          upd_we,
    input  logic [1:0]    upd_sel,
    input  logic [AW-1:0] upd_data,
    output logic [AW-1:0] ptr_x,
    output logic [AW-1:0] ptr_y,
    output logic [AW-1:0] ptr_z
);
    localparam int NPTR = 3;

    logic [AW-1:0] ptr_q [NPTR];

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        // One pointer register: access update first, then external write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[g] <= '0;
            else if (upd_we && upd_sel == 2'(g))
                ptr_q[g] <= upd_data;
            else if (ext_we && ext_sel == 2'(g))
                ptr_q[g] <= ext_data;
        end
    end

    assign ptr_x = ptr_q[0];
    assign ptr_y = ptr_q[1];
    assign ptr_z = ptr_q[2];
endmodule

// File: rtl/agu_addr_calc.sv
// Module: combinational effective-address and pointer-update logic.
// Assumes the pointer inputs are the registered current values. The
// outputs only matter while 'legal' is high.
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int QW = 6
) (
    input  logic [1:0]    op,
    input  logic [1:0]    sel,
    input  logic [2:0]    mode,
    input  logic [QW-1:0] disp,
    input  logic [AW-1:0] imm,
    input  logic [AW-1:0] ptr_x,
    input  logic [AW-1:0] ptr_y,
    input  logic [AW-1:0] ptr_z,
    output logic          legal,
    output logic [1:0]    eff_sel,
    output logic [AW-1:0] eff_addr,
    output logic          upd_en,
    output logic [AW-1:0] upd_val
);
    localparam int PADW = AW - QW;

    logic [AW-1:0] cur;
    logic [AW-1:0] cur_inc;
    logic [AW-1:0] cur_dec;
    logic [AW-1:0] cur_disp;

    // Pick the pointer: a program read always goes through Z.
    always_comb begin
        eff_sel = (op == OP_PMREAD) ? SEL_Z : sel;
        case (eff_sel)
            SEL_X:   cur = ptr_x;
            SEL_Y:   cur = ptr_y;
            default: cur = ptr_z;
        endcase
        cur_inc  = cur + 1'b1;
        cur_dec  = cur - 1'b1;
        cur_disp = cur + {{PADW{1'b0}}, disp};
    end

    // Decode the mode into an address, a legality flag and a write-back.
    always_comb begin
        legal    = 1'b1;
        eff_addr = cur;
        upd_en   = 1'b0;
        upd_val  = cur_inc;
        if (op == 2'd3) begin
            legal = 1'b0;
        end else if (op == OP_PMREAD) begin
            if (mode == MD_POSTINC)
                upd_en = 1'b1;
            else if (mode != MD_PLAIN)
                legal = 1'b0;
        end else if (sel == 2'd3) begin
            legal = 1'b0;
        end else begin
            case (mode)
                MD_PLAIN:   ;
                MD_POSTINC: upd_en = 1'b1;
                MD_PREDEC: begin
                    eff_addr = cur_dec;
                    upd_val  = cur_dec;
                    upd_en   = 1'b1;
                end
                MD_DISP: begin
                    eff_addr = cur_disp;
                    if (sel == SEL_X)
                        legal = 1'b0;
                end
                MD_DIRECT:  eff_addr = imm;
                default:    legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/agu_seq.sv
// Module: access sequencer driving the memory ports.
// Assumes synchronous memories that return read data one cycle after the
// enable and hold it until the next enable. A data access takes 2 busy
// cycles and a program read takes 3.
module agu_seq
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] dm_rdata,
    input  logic [DW-1:0] pm_rdata,
    output logic          busy,
    output logic          dm_en,
    output logic          dm_we,
    output logic [AW-1:0] dm_addr,
    output logic [DW-1:0] dm_wdata,
    output logic          pm_en,
    output logic [AW-1:0] pm_addr,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    seq_state_e    state;
    logic [1:0]    op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    // State walk: issue, an extra wait for program reads, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (accept) state <= ST_ISSUE;
                ST_ISSUE: state <= (op_q == OP_PMREAD) ? ST_WAIT : ST_DONE;
                ST_WAIT:  state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Latch the request when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            op_q    <= op;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // Capture the loaded byte when the access finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == ST_DONE) && (op_q != OP_STORE);
            if (state == ST_DONE && op_q != OP_STORE)
                rd_data <= (op_q == OP_PMREAD) ? pm_rdata : dm_rdata;
        end
    end

    assign busy     = (state != ST_IDLE);
    assign dm_en    = (state == ST_ISSUE) && (op_q != OP_PMREAD);
    assign dm_we    = (state == ST_ISSUE) && (op_q == OP_STORE);
    assign pm_en    = (state == ST_ISSUE) && (op_q == OP_PMREAD);
    assign dm_addr  = addr_q;
    assign pm_addr  = addr_q;
    assign dm_wdata = wdata_q;
endmodule

// File: rtl/ptr_agu.sv
// Module: top of the pointer load/store address generator.
// Accepts one request when idle, updates the chosen pointer at acceptance
// and runs the access through the sequencer. External pointer writes are
// taken only while idle and with no request present.
module ptr_agu #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DISP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_sel,
    input  logic [2:0]        req_mode,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [ADDR_W-1:0] req_imm,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ptr_wr_en,
    input  logic [1:0]        ptr_wr_sel,
    input  logic [ADDR_W-1:0] ptr_wr_data,
    output logic [ADDR_W-1:0] ptr_x,
    output logic [ADDR_W-1:0] ptr_y,
    output logic [ADDR_W-1:0] ptr_z,
    output logic              busy,
    output logic              dm_en,
    output logic              dm_we,
    output logic [ADDR_W-1:0] dm_addr,
    output logic [DATA_W-1:0] dm_wdata,
    input  logic [DATA_W-1:0] dm_rdata,
    output logic              pm_en,
    output logic [ADDR_W-1:0] pm_addr,
    input  logic [DATA_W-1:0] pm_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic              legal;
    logic [1:0]        eff_sel;
    logic [ADDR_W-1:0] eff_addr;
    logic              upd_en;
    logic [ADDR_W-1:0] upd_val;
    logic              accept;
    logic              ext_ok;

    assign accept = req_valid && !busy && legal;
    assign ext_ok = ptr_wr_en && !busy && !req_valid;

    agu_ptr_file #(.AW(ADDR_W)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_we   (ext_ok),
        .ext_sel  (ptr_wr_sel),
        .ext_data (ptr_wr_data),
        .upd_we   (accept && upd_en),
        .upd_sel  (eff_sel),
        .upd_data (upd_val),
        .ptr_x    (ptr_x),
        .ptr_y    (ptr_y),
        .ptr_z    (ptr_z)
    );

    agu_addr_calc #(.AW(ADDR_W), .QW(DISP_W)) u_calc (
        .op       (req_op),
        .sel      (req_sel),
        .mode     (req_mode),
        .disp     (req_disp),
        .imm      (req_imm),
        .ptr_x    (ptr_x),
        .ptr_y    (ptr_y),
        .ptr_z    (ptr_z),
        .legal    (legal),
        .eff_sel  (eff_sel),
        .eff_addr (eff_addr),
        .upd_en   (upd_en),
        .upd_val  (upd_val)
    );

    agu_seq #(.AW(ADDR_W), .DW(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .op       (req_op),
        .addr     (eff_addr),
        .wdata    (req_wdata),
        .dm_rdata (dm_rdata),
        .pm_rdata (pm_rdata),
        .busy     (busy),
        .dm_en    (dm_en),
        .dm_we    (dm_we),
        .dm_addr  (dm_addr),
        .dm_wdata (dm_wdata),
        .pm_en    (pm_en),
        .pm_addr  (pm_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/agu_chk.sv
// Module: protocol checker for ptr_agu, attached by bind.
// Watches only the top-level ports.
module agu_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic dm_en,
    input logic dm_we,
    input logic pm_en,
    input logic rd_valid
);
    // R9: a data access stays busy one more cycle, then ends.
    assert_dm_two_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dm_en |=> (busy && !dm_en) ##1 !busy);

    // R10: a program read stays busy two more cycles, then ends.
    assert_pm_three_cycles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pm_en |=> busy ##1 busy ##1 !busy);

    // R8: a write strobe only appears inside a data access.
    assert_we_inside_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> dm_en);

    // R11: a new access only starts after a non-busy cycle.
    assert_issue_after_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_en || pm_en) |-> !$past(busy));

    // R9: the result strobe directly follows the end of busy.
    assert_valid_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!busy && $past(busy)));
endmodule

bind ptr_agu agu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .dm_en    (dm_en),
    .dm_we    (dm_we),
    .pm_en    (pm_en),
    .rd_valid (rd_valid)
);

// File: tb/sim_ptr_agu.sv
// Directed bench for ptr_agu: one task per scenario, with models of both memories.
module sim_ptr_agu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_sel = 2'd0;
    logic [2:0]  req_mode = 3'd0;
    logic [5:0]  req_disp = 6'd0;
    logic [15:0] req_imm = 16'd0;
    logic [7:0]  req_wdata = 8'd0;
    logic        ptr_wr_en = 1'b0;
    logic [1:0]  ptr_wr_sel = 2'd0;
    logic [15:0] ptr_wr_data = 16'd0;
    logic [15:0] ptr_x, ptr_y, ptr_z;
    logic        busy, dm_en, dm_we, pm_en, rd_valid;
    logic [15:0] dm_addr, pm_addr;
    logic [7:0]  dm_wdata, rd_data;
    logic [7:0]  dm_rdata = 8'd0;
    logic [7:0]  pm_rdata = 8'd0;
    logic [7:0]  dmem [256];
    int          n_tests = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ptr_agu u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_mode(req_mode), .req_disp(req_disp),
        .req_imm(req_imm), .req_wdata(req_wdata), .ptr_wr_en(ptr_wr_en),
        .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data), .ptr_x(ptr_x),
        .ptr_y(ptr_y), .ptr_z(ptr_z), .busy(busy), .dm_en(dm_en),
        .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_rdata(dm_rdata), .pm_en(pm_en), .pm_addr(pm_addr),
        .pm_rdata(pm_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Data memory model: 256 bytes, indexed by the low address byte.
    always @(posedge clk) begin
        if (dm_en) begin
            if (dm_we) dmem[dm_addr[7:0]] <= dm_wdata;
            else       dm_rdata <= dmem[dm_addr[7:0]];
        end
    end

    // Program memory model: content computed from the address.
    always @(posedge clk) begin
        if (pm_en) pm_rdata <= pm_addr[7:0] ^ 8'hA5;
    end

    function automatic logic [7:0] dm_init(input logic [15:0] a);
        return 8'(a[7:0] * 3 + 1);
    endfunction

    function automatic logic [15:0] ptr_of(input logic [1:0] s);
        return (s == 2'd0) ? ptr_x : (s == 2'd1) ? ptr_y : ptr_z;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        ptr_wr_en = 1'b1; ptr_wr_sel = s; ptr_wr_data = v;
        @(negedge clk);
        ptr_wr_en = 1'b0;
        chk(ptr_of(s) == v, "R12 pointer write", ptr_of(s), v);
    endtask

    task automatic drive_req(input logic [1:0] op, input logic [1:0] s, input logic [2:0] m,
                             input logic [5:0] q, input logic [15:0] k, input logic [7:0] wd);
        req_valid = 1'b1; req_op = op; req_sel = s; req_mode = m;
        req_disp = q; req_imm = k; req_wdata = wd;
    endtask

    // Full access: checks the address, the pointer, busy length and the result.
    task automatic run_access(input logic [1:0] op, input logic [1:0] s, input logic [2:0] m,
                              input logic [5:0] q, input logic [15:0] k, input logic [7:0] wd,
                              input logic [15:0] exp_addr, input logic [15:0] exp_ptr,
                              input logic [7:0] exp_data, input string tag);
        logic [1:0] ps;
        ps = (op == 2'd2) ? 2'd2 : s;
        @(negedge clk);
        drive_req(op, s, m, q, k, wd);
        @(negedge clk);
        req_valid = 1'b0;
        if (op == 2'd2) begin
            chk(pm_en && !dm_en, {tag, " pm_en"}, {15'd0, pm_en}, 16'd1);
            chk(pm_addr == exp_addr, {tag, " address"}, pm_addr, exp_addr);
        end else begin
            chk(dm_en && !pm_en, {tag, " dm_en"}, {15'd0, dm_en}, 16'd1);
            chk(dm_addr == exp_addr, {tag, " address"}, dm_addr, exp_addr);
            chk(dm_we == (op == 2'd1), {tag, " R8 we"}, {15'd0, dm_we}, {15'd0, op == 2'd1});
            if (op == 2'd1) chk(dm_wdata == wd, {tag, " R8 wdata"}, {8'd0, dm_wdata}, {8'd0, wd});
        end
        chk(ptr_of(ps) == exp_ptr, {tag, " pointer"}, ptr_of(ps), exp_ptr);
        chk(busy, {tag, " R9 busy c1"}, {15'd0, busy}, 16'd1);
        @(negedge clk);
        chk(busy, {tag, " R9 busy c2"}, {15'd0, busy}, 16'd1);
        if (op == 2'd2) begin
            @(negedge clk);
            chk(busy, {tag, " R10 busy c3"}, {15'd0, busy}, 16'd1);
        end
        @(negedge clk);
        chk(!busy, {tag, " R9 busy end"}, {15'd0, busy}, 16'd0);
        if (op != 2'd1) begin
            chk(rd_valid, {tag, " R9 rd_valid"}, {15'd0, rd_valid}, 16'd1);
            chk(rd_data == exp_data, {tag, " data"}, {8'd0, rd_data}, {8'd0, exp_data});
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ptr_x == 0 && ptr_y == 0 && ptr_z == 0, "R1 pointers", ptr_x | ptr_y | ptr_z, 16'd0);
        chk(!busy && !dm_en && !dm_we && !pm_en && !rd_valid, "R1 outputs",
            {11'd0, busy, dm_en, dm_we, pm_en, rd_valid}, 16'd0);
    endtask

    task automatic t_plain();
        set_ptr(2'd0, 16'h0010);
        set_ptr(2'd1, 16'h0020);
        set_ptr(2'd2, 16'hFFFF);
        run_access(2'd0, 2'd0, 3'd0, 6'd0, 16'd0, 8'd0, 16'h0010, 16'h0010, dm_init(16'h0010), "R2 plain X");
    endtask

    task automatic t_postinc();
        run_access(2'd0, 2'd2, 3'd1, 6'd0, 16'd0, 8'd0, 16'hFFFF, 16'h0000, dm_init(16'hFFFF), "R3 postinc wrap");
    endtask

    task automatic t_predec();
        run_access(2'd0, 2'd0, 3'd2, 6'd0, 16'd0, 8'd0, 16'h000F, 16'h000F, dm_init(16'h000F), "R4 predec");
        set_ptr(2'd0, 16'h0000);
        run_access(2'd0, 2'd0, 3'd2, 6'd0, 16'd0, 8'd0, 16'hFFFF, 16'hFFFF, dm_init(16'hFFFF), "R4 predec wrap");
    endtask

    task automatic t_disp();
        run_access(2'd0, 2'd1, 3'd3, 6'd63, 16'd0, 8'd0, 16'h005F, 16'h0020, dm_init(16'h005F), "R5 disp Y max q");
        set_ptr(2'd2, 16'hFFF0);
        run_access(2'd0, 2'd2, 3'd3, 6'h20, 16'd0, 8'd0, 16'h0010, 16'hFFF0, dm_init(16'h0010), "R5 disp Z wrap");
    endtask

    task automatic t_reject();
        @(negedge clk);
        drive_req(2'd0, 2'd0, 3'd3, 6'd5, 16'd0, 8'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!busy && !dm_en && !pm_en, "R6 disp on X refused", {14'd0, busy, dm_en}, 16'd0);
        chk(ptr_x == 16'hFFFF, "R6 X unchanged", ptr_x, 16'hFFFF);
        @(negedge clk);
        drive_req(2'd1, 2'd1, 3'd5, 6'd0, 16'd0, 8'h77);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!busy && !dm_en && !dm_we, "R6 mode 5 refused", {14'd0, busy, dm_we}, 16'd0);
        @(negedge clk);
        drive_req(2'd2, 2'd2, 3'd2, 6'd0, 16'd0, 8'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!busy && !pm_en && ptr_z == 16'hFFF0, "R6 R10 pm predec refused", ptr_z, 16'hFFF0);
    endtask

    task automatic t_direct();
        run_access(2'd0, 2'd1, 3'd4, 6'd0, 16'h1234, 8'd0, 16'h1234, 16'h0020, dm_init(16'h1234), "R7 direct");
    endtask

    task automatic t_store();
        run_access(2'd1, 2'd1, 3'd1, 6'd0, 16'd0, 8'hC3, 16'h0020, 16'h0021, 8'd0, "R8 store Y postinc");
        run_access(2'd0, 2'd0, 3'd4, 6'd0, 16'h0020, 8'd0, 16'h0020, 16'hFFFF, 8'hC3, "R8 readback");
        run_access(2'd1, 2'd2, 3'd2, 6'd0, 16'd0, 8'h5A, 16'hFFEF, 16'hFFEF, 8'd0, "R8 store Z predec");
        run_access(2'd0, 2'd0, 3'd4, 6'd0, 16'hFFEF, 8'd0, 16'hFFEF, 16'hFFFF, 8'h5A, "R8 readback 2");
    endtask

    task automatic t_pmread();
        set_ptr(2'd2, 16'h0040);
        run_access(2'd2, 2'd2, 3'd1, 6'd0, 16'd0, 8'd0, 16'h0040, 16'h0041, 8'h40 ^ 8'hA5, "R10 pm postinc");
        run_access(2'd2, 2'd0, 3'd0, 6'd0, 16'd0, 8'd0, 16'h0041, 16'h0041, 8'h41 ^ 8'hA5, "R10 pm uses Z");
    endtask

    task automatic t_overlap();
        @(negedge clk);
        drive_req(2'd0, 2'd0, 3'd0, 6'd0, 16'd0, 8'd0);
        @(negedge clk);
        drive_req(2'd0, 2'd0, 3'd1, 6'd0, 16'd0, 8'd0);
        chk(dm_en && dm_addr == 16'hFFFF, "R11 first access", dm_addr, 16'hFFFF);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!dm_en && ptr_x == 16'hFFFF, "R11 busy request ignored", ptr_x, 16'hFFFF);
        @(negedge clk);
        chk(rd_valid && rd_data == dm_init(16'hFFFF), "R11 first result", {8'd0, rd_data}, {8'd0, dm_init(16'hFFFF)});
        drive_req(2'd0, 2'd1, 3'd4, 6'd0, 16'h0011, 8'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(dm_en && dm_addr == 16'h0011, "R11 accepted in result cycle", dm_addr, 16'h0011);
        @(negedge clk);
        @(negedge clk);
        chk(rd_valid && rd_data == dm_init(16'h0011), "R11 second result", {8'd0, rd_data}, {8'd0, dm_init(16'h0011)});
    endtask

    task automatic t_wr_drop();
        @(negedge clk);
        drive_req(2'd0, 2'd1, 3'd0, 6'd0, 16'd0, 8'd0);
        ptr_wr_en = 1'b1; ptr_wr_sel = 2'd1; ptr_wr_data = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        ptr_wr_data = 16'hCAFE;
        @(negedge clk);
        ptr_wr_en = 1'b0;
        @(negedge clk);
        chk(ptr_y == 16'h0021, "R12 writes with request or busy dropped", ptr_y, 16'h0021);
        chk(rd_valid && rd_data == dm_init(16'h0021), "R12 access unaffected", {8'd0, rd_data}, {8'd0, dm_init(16'h0021)});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = dm_init(16'(i));
        t_reset();
        t_plain();
        t_postinc();
        t_predec();
        t_disp();
        t_reject();
        t_direct();
        t_store();
        t_pmread();
        t_overlap();
        t_wr_drop();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog expired: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule